// File: doc/BRIEF.md
# Two-Channel Burst PWM Generator

This block drives two pulse outputs whose high time and low time are each set separately as a whole number of timebase units (one unit is 100 us at the default clock). Each channel also carries a pulse budget: once armed, the channel emits that many high/low pairs and then parks with its output low. A budget of zero lets the channel run without end.

Configuration arrives as short commands from a mailbox interpreter: an 8-bit command code plus a 16-bit argument. Codes select a channel's high time, low time or pulse budget, or a shared enable mask with one bit per channel. Software is expected to clear a channel's enable bit before reprogramming it, then set the bit again to start a fresh burst. The command port follows valid/ready rules. `cmd_ready` is held high at all times, so the block never applies back-pressure, and a command is taken on every rising clock edge where `cmd_valid` is high. The pulse outputs are plain level signals.

Top module: `pwm_burst_gen`

## Requirements
- R1: A command transfers on any rising edge with `cmd_valid` high; `cmd_ready` is always 1. For channel n (0 or 1), code 0x10+2n loads the high time, 0x11+2n loads the low time and 0x14+n loads the pulse budget from `cmd_data`. Code 0x1F loads the enable mask from `cmd_data[1:0]`, where bit n enables channel n. Every other code changes nothing.
- R2: After reset both outputs are low, the mask is 0, the high and low times are 1 unit and the budgets are 0. A high or low time written as 0 behaves as 1 unit.
- R3: One unit lasts `TICK_CYCLES` clock cycles.
- R4: When a channel is enabled from idle, its output rises on the clock edge after the edge that updated the mask. It then stays high for (high time × `TICK_CYCLES`) cycles and low for (low time × `TICK_CYCLES`) cycles, and this pair repeats.
- R5: With a budget N > 0, exactly N high/low pairs are produced. The output then stays low while the enable bit remains set. Clearing the bit and setting it again re-arms a full burst.
- R6: With a budget of 0, the channel repeats pairs until its enable bit is cleared.
- R7: Clearing a channel's enable bit drives its output low right after the edge that updates the mask. Re-enabling later starts again from a full high time.
- R8: High time, low time and budget are captured when a channel starts. Writes to them during a burst take effect only at the next arm.
- R9: Rewriting the mask with a channel's bit already set has no effect on that channel's waveform.
- R10: The two channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_code | input | 8 | Command code |
| cmd_data | input | 16 | Command argument |
| pwm_out | output | 2 | Pulse output, bit n is channel n |

## Verification
On every cycle, the assertions check the following: the prescaler stays in range and wraps after its last count; the unit counter stays below the captured high or low time; the pair counter stays under a nonzero budget; a budget of zero never reaches the finished state; the captured settings hold still while a burst runs; disabling clears the counters; and an unknown code leaves all state untouched. Only the bench scenarios can show the exact edge on which an output rises or falls, the full length of each phase, the number of pulses in a burst, re-arming, and the default values after reset. The same holds for how writes made mid-burst and mask rewrites appear at the pins.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CODE_W = 8;
  localparam int VAL_W  = 16;

  localparam logic [CODE_W-1:0] CMD_HI_BASE    = 8'h10;
  localparam logic [CODE_W-1:0] CMD_LO_BASE    = 8'h11;
  localparam logic [CODE_W-1:0] CMD_BURST_BASE = 8'h14;
  localparam logic [CODE_W-1:0] CMD_ENABLE     = 8'h1F;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_HIGH,
    CH_LOW,
    CH_DONE
  } ch_state_t;

  typedef struct packed {
    logic [VAL_W-1:0] hi;
    logic [VAL_W-1:0] lo;
    logic [VAL_W-1:0] burst;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_cmd_regs.sv
module pwm_cmd_regs
  import pwm_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [VAL_W-1:0]    cmd_data,
  output ch_cfg_t [NCH-1:0]   cfg,
  output logic [NCH-1:0]      en_mask
);
  localparam int NHIT = 3 * NCH;

  logic [NHIT-1:0]  hit;
  logic             hit_en;
  logic             known;
  logic [VAL_W-1:0] clamped;

  // zero durations are stored as one unit
  assign clamped = (cmd_data == '0) ? VAL_W'(1) : cmd_data;
  assign hit_en  = cmd_valid && (cmd_code == CMD_ENABLE);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [CODE_W-1:0] HI_C = CMD_HI_BASE + CODE_W'(2 * n);
    localparam logic [CODE_W-1:0] LO_C = CMD_LO_BASE + CODE_W'(2 * n);
    localparam logic [CODE_W-1:0] BU_C = CMD_BURST_BASE + CODE_W'(n);

    logic [VAL_W-1:0] hi_q, lo_q, burst_q;

    assign hit[3*n]   = cmd_valid && (cmd_code == HI_C);
    assign hit[3*n+1] = cmd_valid && (cmd_code == LO_C);
    assign hit[3*n+2] = cmd_valid && (cmd_code == BU_C);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q    <= VAL_W'(1);
        lo_q    <= VAL_W'(1);
        burst_q <= '0;
      end else begin
        if (hit[3*n])   hi_q    <= clamped;
        if (hit[3*n+1]) lo_q    <= clamped;
        if (hit[3*n+2]) burst_q <= cmd_data;
      end
    end

    assign cfg[n] = '{hi: hi_q, lo: lo_q, burst: burst_q};

    // R2: durations never hold zero
    a_r2_nonzero_time: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_q != '0) && (lo_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_mask <= '0;
    else if (hit_en) en_mask <= cmd_data[NCH-1:0];
  end

  assign known = (|hit) || hit_en;

  // R1: unrecognised codes leave every register untouched
  a_r1_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known) |=> ($stable(en_mask) && $stable(cfg)));
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign last = run && (cnt == TOP);

  // R3: count stays inside one unit
  a_r3_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  // R3: a unit boundary restarts the count
  a_r3_prescale_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int DIV = 5000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  ch_cfg_t cfg_in,
  output logic    out
);
  ch_state_t        state;
  logic [VAL_W-1:0] hi_l, lo_l, burst_l;
  logic [VAL_W-1:0] unit_cnt, done_cnt;
  logic             tick_last;
  logic             running;

  assign running = en && ((state == CH_HIGH) || (state == CH_LOW));

  pwm_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (running),
    .last (tick_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CH_IDLE;
      hi_l     <= VAL_W'(1);
      lo_l     <= VAL_W'(1);
      burst_l  <= '0;
      unit_cnt <= '0;
      done_cnt <= '0;
    end else if (!en) begin
      state    <= CH_IDLE;
      unit_cnt <= '0;
      done_cnt <= '0;
    end else begin
      unique case (state)
        CH_IDLE: begin
          hi_l     <= cfg_in.hi;
          lo_l     <= cfg_in.lo;
          burst_l  <= cfg_in.burst;
          unit_cnt <= '0;
          done_cnt <= '0;
          state    <= CH_HIGH;
        end
        CH_HIGH: if (tick_last) begin
          if (unit_cnt == hi_l - VAL_W'(1)) begin
            unit_cnt <= '0;
            state    <= CH_LOW;
          end else begin
            unit_cnt <= unit_cnt + VAL_W'(1);
          end
        end
        CH_LOW: if (tick_last) begin
          if (unit_cnt == lo_l - VAL_W'(1)) begin
            unit_cnt <= '0;
            if (burst_l == '0) begin
              state <= CH_HIGH;
            end else begin
              done_cnt <= done_cnt + VAL_W'(1);
              state    <= (done_cnt + VAL_W'(1) == burst_l) ? CH_DONE : CH_HIGH;
            end
          end else begin
            unit_cnt <= unit_cnt + VAL_W'(1);
          end
        end
        default: state <= CH_DONE;
      endcase
    end
  end

  assign out = en && (state == CH_HIGH);

  // R4: unit counter stays below the captured phase length
  a_r4_unit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == CH_HIGH) |-> (unit_cnt < hi_l)) and ((state == CH_LOW) |-> (unit_cnt < lo_l)));
  // R5: pairs produced never exceed a nonzero budget before finishing
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_l != '0 && state != CH_DONE && state != CH_IDLE) |-> (done_cnt < burst_l));
  // R6: a zero budget never finishes
  a_r6_no_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (state != CH_IDLE && burst_l == '0) |-> (state != CH_DONE));
  // R7: disabling clears the counters
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (unit_cnt == '0 && done_cnt == '0 && state == CH_IDLE));
  // R8: captured settings hold during a burst
  a_r8_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state != CH_IDLE) |=> ($stable(hi_l) && $stable(lo_l) && $stable(burst_l)));
endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int TICK_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [VAL_W-1:0]  cmd_data,
  output logic [NCH-1:0]    pwm_out
);
  ch_cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0]    en_mask;

  assign cmd_ready = 1'b1;

  pwm_cmd_regs #(.NCH(NCH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .cmd_data (cmd_data),
    .cfg      (cfg),
    .en_mask  (en_mask)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    pwm_channel #(.DIV(TICK_CYCLES)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_mask[n]),
      .cfg_in(cfg[n]),
      .out   (pwm_out[n])
    );
  end
endmodule

// File: tb/pwm_burst_gen_bench.sv
module pwm_burst_gen_bench;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_code = '0;
  logic [15:0] cmd_data = '0;
  logic [1:0]  pwm_out;

  int errors = 0;
  int checks = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  pwm_burst_gen #(.NCH(2), .TICK_CYCLES(P)) u_pwm_burst_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] code, input logic [15:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // expected output t cycles after the negedge that follows the mask update
  function automatic bit exp_out(int t, int hi, int lo, int n);
    int u, per, k;
    if (t == 0) return 1'b0;
    u = t - 1;
    per = (hi + lo) * P;
    k = u / per;
    if (n != 0 && k >= n) return 1'b0;
    return (u % per) < hi * P;
  endfunction

  task automatic check_window(input int ch, input int hi, input int lo, input int n,
                              input int len, input string req);
    int bad_t = -1;
    bit bad_a = 0, bad_e = 0;
    for (int t = 0; t < len; t++) begin
      if (bad_t < 0 && pwm_out[ch] !== exp_out(t, hi, lo, n)) begin
        bad_t = t; bad_a = pwm_out[ch]; bad_e = exp_out(t, hi, lo, n);
      end
      @(negedge clk);
    end
    checks++;
    if (bad_t >= 0) begin
      errors++;
      $display("FAIL %s ch%0d at t=%0d actual=%0b expected=%0b", req, ch, bad_t, bad_a, bad_e);
    end
  endtask

  task automatic check_low(input int ch, input int len, input string req);
    int bad_t = -1;
    for (int t = 0; t < len; t++) begin
      if (bad_t < 0 && pwm_out[ch] !== 1'b0) bad_t = t;
      @(negedge clk);
    end
    checks++;
    if (bad_t >= 0) begin
      errors++;
      $display("FAIL %s ch%0d high at t=%0d actual=1 expected=0", req, ch, bad_t);
    end
  endtask

  task automatic t_reset;
    check(pwm_out == 2'b00, "R2 outputs low after reset", pwm_out, 0);
    check(cmd_ready == 1'b1, "R1 ready held high", cmd_ready, 1);
  endtask

  task automatic t_unknown_and_defaults;
    send_cmd(8'h1E, 16'h0003);
    send_cmd(8'h16, 16'h0002);
    send_cmd(8'h17, 16'h0005);
    check_low(0, 12, "R1 unknown codes ignored");
    send_cmd(8'h1F, 16'h0001);
    check_window(0, 1, 1, 0, 40, "R2 default 1/1 units, budget 0");
    send_cmd(8'h1F, 16'h0000);
  endtask

  task automatic t_burst;
    send_cmd(8'h10, 16'd2);
    send_cmd(8'h11, 16'd3);
    send_cmd(8'h14, 16'd3);
    send_cmd(8'h1F, 16'h0001);
    fork
      check_window(0, 2, 3, 3, 80, "R3/R4 phase lengths and R5 budget of 3");
      check_low(1, 80, "R10 idle channel unaffected");
    join
    check_low(0, 20, "R5 stays low while enabled after burst");
  endtask

  task automatic t_rearm;
    send_cmd(8'h1F, 16'h0000);
    send_cmd(8'h1F, 16'h0001);
    check_window(0, 2, 3, 3, 70, "R5 re-arm repeats burst");
  endtask

  task automatic t_disable;
    send_cmd(8'h1F, 16'h0000);
    send_cmd(8'h10, 16'd3);
    send_cmd(8'h11, 16'd1);
    send_cmd(8'h14, 16'd0);
    send_cmd(8'h1F, 16'h0001);
    repeat (5) @(negedge clk);
    send_cmd(8'h1F, 16'h0000);
    check(pwm_out[0] == 1'b0, "R7 output low after disable", pwm_out[0], 0);
    send_cmd(8'h1F, 16'h0001);
    check_window(0, 3, 1, 0, 50, "R7 restart with full high time");
  endtask

  task automatic t_midburst_writes;
    send_cmd(8'h1F, 16'h0000);
    send_cmd(8'h10, 16'd2);
    send_cmd(8'h11, 16'd2);
    send_cmd(8'h14, 16'd2);
    send_cmd(8'h1F, 16'h0001);
    fork
      check_window(0, 2, 2, 2, 50, "R8 writes mid-burst deferred, R9 mask rewrite");
      begin
        repeat (3) @(negedge clk);
        send_cmd(8'h10, 16'd5);
        send_cmd(8'h14, 16'd0);
        send_cmd(8'h1F, 16'h0001);
      end
    join
    send_cmd(8'h1F, 16'h0000);
    send_cmd(8'h1F, 16'h0001);
    check_window(0, 5, 2, 0, 70, "R8 new settings after re-arm");
  endtask

  task automatic t_both;
    send_cmd(8'h1F, 16'h0000);
    send_cmd(8'h12, 16'd0);
    send_cmd(8'h13, 16'd2);
    send_cmd(8'h15, 16'd0);
    send_cmd(8'h10, 16'd1);
    send_cmd(8'h11, 16'd1);
    send_cmd(8'h14, 16'd4);
    send_cmd(8'h1F, 16'h0003);
    fork
      check_window(1, 1, 2, 0, 150, "R6 continuous, R2 zero high as 1 unit");
      check_window(0, 1, 1, 4, 150, "R10 ch0 independent burst of 4");
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unknown_and_defaults();
    t_burst();
    t_rearm();
    t_disable();
    t_midburst_writes();
    t_both();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule